// File: doc/BRIEF.md
# Shadow-Buffered Left-Aligned PWM Channel

This block is one pulse-width modulation channel with an 8-bit up-counter, an active compare pair (period and duty) and a shadow pair that software writes. A plain synchronous register port writes the control bits, the shadowed period and duty, and the counter. It reads back the control bits, the shadow values and the live count. The counter advances only on a one-cycle tick from an external prescaler. The channel drives a single output pin.

While the channel runs, new period and duty values wait in the shadow pair. They move into the active pair at three points: when the cycle wraps, when the counter is written, or when the channel stops. Every output cycle therefore uses either the complete old setting or the complete new one. Writing the counter clears it and applies the shadow values at once. This gives software a way to force a change in the middle of a cycle, and that cycle may come out shortened.

The register port has no handshake. It accepts one access per clock, and reads return data in the same cycle, so it applies no back-pressure. The tick input and the output pin are plain level signals.

Top module: `pwm_chan`

## Requirements
- R1: After reset the count reads 0, the control, period and duty registers read 0, the channel is stopped, and `pwm_out` is 0.
- R2: Register addresses are 0 = control (bit 0 enable, bit 1 polarity, other bits read 0), 1 = period, 2 = duty, 3 = count. Reads of 1 and 2 return the shadow values, and a read of 3 returns the live counter.
- R3: While the channel runs, each tick adds one to the counter. The tick that finds the counter at period−1 or above sets it to 0 instead, so a cycle lasts `period` ticks. With period 0 the counter stays at 0.
- R4: While the channel is stopped, the counter holds its value. A change to the enable bit takes effect only on the next tick, and no counting happens before that tick.
- R5: While the channel runs, `pwm_out` equals the polarity bit when count < active duty, and its inverse otherwise. Duty 0 therefore gives the inverse level for the whole cycle, and a duty ≥ period gives the polarity level for the whole cycle.
- R6: While the channel is stopped, `pwm_out` is 0.
- R7: While the channel runs, period and duty writes change only the shadow values. The active values change only at a load event, and the wrap tick is one such event.
- R8: While the channel is stopped, period and duty writes update the shadow value and the active value in the same cycle.
- R9: A write of any value to the count register sets the counter to 0 and copies the shadow values into the active pair, whether the channel runs or not.
- R10: The tick that stops a running channel copies the shadow values into the active pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count enable from the prescaler |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per asserted cycle |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM output pin |

## Verification
The assertions check on every cycle that the counter stays still without a tick, steps by one or wraps on a tick, and clears after a count write. They also check that the run state changes only on a tick, that the active pair stays fixed while running between load events, and that direct writes land while stopped. The bench sweeps each output waveform over a range of period, duty and polarity values. It also checks the ordering between a shadow write and the wrap that applies it. Some effects appear only at the pin over a whole cycle: a forced mid-cycle reload, the stop-time load, and a delayed enable. Only the bench scenarios show these.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 2'd0,
    RA_PERIOD = 2'd1,
    RA_DUTY   = 2'd2,
    RA_COUNT  = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_POL_BIT = 1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              period_end,
  output logic              en_q,
  output logic              pol_q,
  output logic              run_q,
  output logic              cnt_wr,
  output logic [W-1:0]      per_buf,
  output logic [W-1:0]      duty_buf,
  output logic [W-1:0]      per_act,
  output logic [W-1:0]      duty_act
);
  logic         wr_ctrl, wr_per, wr_duty;
  logic         stop_evt, load;
  logic [W-1:0] per_buf_d, duty_buf_d;

  always_comb begin
    wr_ctrl    = wr_en && (wr_addr == RA_CTRL);
    wr_per     = wr_en && (wr_addr == RA_PERIOD);
    wr_duty    = wr_en && (wr_addr == RA_DUTY);
    cnt_wr     = wr_en && (wr_addr == RA_COUNT);
    per_buf_d  = wr_per  ? wr_data : per_buf;
    duty_buf_d = wr_duty ? wr_data : duty_buf;
    // stopping takes effect on a tick; that same tick commits the shadows
    stop_evt   = tick && run_q && !en_q;
    load       = cnt_wr || period_end || stop_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pol_q    <= 1'b0;
      run_q    <= 1'b0;
      per_buf  <= '0;
      duty_buf <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wr_data[CTRL_EN_BIT];
        pol_q <= wr_data[CTRL_POL_BIT];
      end
      if (tick) run_q <= en_q;
      per_buf  <= per_buf_d;
      duty_buf <= duty_buf_d;
      if (load || (!run_q && wr_per))  per_act  <= per_buf_d;
      if (load || (!run_q && wr_duty)) duty_act <= duty_buf_d;
    end
  end

  // R7: a running channel keeps its compare pair between load events
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load) |=> ($stable(per_act) && $stable(duty_act)));

  // R4: run state only moves on a tick
  p_run_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(run_q));

  // R8: a stopped channel takes period writes directly
  p_direct_per_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && wr_per) |=> (per_act == $past(wr_data)));

  // R8: a stopped channel takes duty writes directly
  p_direct_duty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && wr_duty) |=> (duty_act == $past(wr_data)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         period_end
);
  logic [W:0] next_ext;
  logic       wrap;

  always_comb begin
    next_ext   = {1'b0, count} + {{W{1'b0}}, 1'b1};
    // also covers period 0 and a count left above a shrunk period
    wrap       = (next_ext >= {1'b0, period});
    period_end = tick && run && !clr && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clr)            count <= '0;
    else if (tick && run)    count <= wrap ? '0 : next_ext[W-1:0];
  end

  // R4: no tick and no write, no movement
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(count));

  // R4: stopped counter ignores ticks
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(count));

  // R9: a count write clears the counter
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R3: ticks below the wrap point step by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !clr && !wrap) |=> (count == $past(count) + 1'b1));

  // R3: the wrap tick returns to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (count == '0));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int unsigned W = 8
) (
  input  logic         run,
  input  logic         pol,
  input  logic [W-1:0] count,
  input  logic [W-1:0] duty,
  output logic         wave
);
  logic before_duty;

  always_comb begin
    before_duty = (count < duty);
    if (!run) wave = 1'b0;
    else      wave = before_duty ? pol : !pol;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_we,
  output logic [W-1:0]      bus_rdata,
  output logic              pwm_out
);
  logic         en_q, pol_q, run_q, cnt_wr, period_end;
  logic [W-1:0] per_buf, duty_buf, per_act, duty_act, count;

  pwm_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (bus_we),
    .wr_addr    (bus_addr),
    .wr_data    (bus_wdata),
    .period_end (period_end),
    .en_q       (en_q),
    .pol_q      (pol_q),
    .run_q      (run_q),
    .cnt_wr     (cnt_wr),
    .per_buf    (per_buf),
    .duty_buf   (duty_buf),
    .per_act    (per_act),
    .duty_act   (duty_act)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .run        (run_q),
    .clr        (cnt_wr),
    .period     (per_act),
    .count      (count),
    .period_end (period_end)
  );

  pwm_wave #(.W(W)) u_wave (
    .run   (run_q),
    .pol   (pol_q),
    .count (count),
    .duty  (duty_act),
    .wave  (pwm_out)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL: begin
        bus_rdata[CTRL_EN_BIT]  = en_q;
        bus_rdata[CTRL_POL_BIT] = pol_q;
      end
      RA_PERIOD: bus_rdata = per_buf;
      RA_DUTY:   bus_rdata = duty_buf;
      default:   bus_rdata = count;
    endcase
  end

  // R6: a stopped channel drives low on the next cycle after stopping
  p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en_q) |=> !pwm_out);
endmodule

// File: tb/pwm_chan_bench.sv
module pwm_chan_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] bus_addr = 2'd3;
  logic [7:0] bus_wdata = 8'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       pwm_out;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state, built from the requirements
  int m_cnt, mb_per, mb_dut, ma_per, ma_dut;
  bit m_en, m_pol, m_run;

  always #10 clk = ~clk;

  pwm_chan u_pwm_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = a[1:0]; bus_wdata = d[7:0]; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      0: begin m_en = d[0]; m_pol = d[1]; end
      1: begin mb_per = d; if (!m_run) ma_per = d; end
      2: begin mb_dut = d; if (!m_run) ma_dut = d; end
      default: begin m_cnt = 0; ma_per = mb_per; ma_dut = mb_dut; end
    endcase
  endtask

  task automatic tk();
    bit wrapped;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    wrapped = 1'b0;
    if (m_run) begin
      wrapped = (m_cnt + 1 >= ma_per);
      m_cnt = wrapped ? 0 : m_cnt + 1;
      if (wrapped || !m_en) begin ma_per = mb_per; ma_dut = mb_dut; end
    end
    m_run = m_en;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = a[1:0];
    #1;
    v = bus_rdata;
  endtask

  task automatic chk(input string tag);
    int v, e;
    rd(3, v);
    cmp({tag, " count"}, v, m_cnt);
    e = !m_run ? 0 : ((m_cnt < ma_dut) ? int'(m_pol) : int'(!m_pol));
    cmp({tag, " out"}, int'(pwm_out), e);
  endtask

  task automatic setup(input int p, input int d, input bit pol);
    wr(0, {pol, 1'b0});
    tk();
    wr(1, p); wr(2, d); wr(3, 0);
    wr(0, {pol, 1'b1});
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v;
    m_cnt = 0; mb_per = 0; mb_dut = 0; ma_per = 0; ma_dut = 0;
    m_en = 0; m_pol = 0; m_run = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 readback layout
    chk("R1");
    rd(0, v); cmp("R1 R2 ctrl", v, 0);
    rd(1, v); cmp("R1 R2 period", v, 0);
    rd(2, v); cmp("R1 R2 duty", v, 0);

    // R3 R5 R6 sweep over period, duty and polarity
    for (int pol = 0; pol < 2; pol++)
      for (int p = 0; p < 6; p++)
        for (int d = 0; d < 7; d++) begin
          setup(p, d, pol[0]);
          chk("R4 R6 pre-tick");
          tk();
          for (int i = 0; i < 2 * p + 2; i++) begin
            chk("R3 R5");
            tk();
          end
        end

    // R2 control readback
    wr(0, 8'hFF);
    rd(0, v); cmp("R2 ctrl bits", v, 3);

    // R4: enable waits for a tick
    setup(4, 2, 1'b1);
    repeat (3) @(negedge clk);
    chk("R4 no tick");
    tk();
    chk("R4 after tick");

    // R7: shadow write mid-cycle applies only at wrap
    tk();
    wr(1, 6); wr(2, 3);
    rd(1, v); cmp("R2 R7 shadow period", v, 6);
    rd(2, v); cmp("R2 R7 shadow duty", v, 3);
    for (int i = 0; i < 12; i++) begin
      chk("R7");
      tk();
    end

    // R9: count write forces reload mid-cycle
    wr(1, 3); wr(2, 1);
    tk();
    chk("R7 pending");
    wr(3, 0);
    chk("R9 cleared");
    for (int i = 0; i < 7; i++) begin
      chk("R9");
      tk();
    end

    // R10: stopping commits shadows, R4 hold, R6 low
    wr(1, 5); wr(2, 4);
    wr(0, 2);
    chk("R10 before stop tick");
    tk();
    chk("R6 R10 stopped");
    for (int i = 0; i < 3; i++) begin
      tk();
      chk("R4 hold");
    end
    wr(0, 3);
    tk();
    for (int i = 0; i < 10; i++) begin
      chk("R10 new cycle");
      tk();
    end

    // R8: direct write while stopped, visible once running
    wr(0, 0);
    tk();
    wr(2, 0);
    wr(0, 1);
    tk();
    chk("R8 duty direct");
    for (int i = 0; i < 6; i++) begin
      chk("R8");
      tk();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule